// File: doc/BRIEF.md
# Byte-Packed Parallel I2S Player

This block plays back a stream of bytes that host software has already shaped into I2S waveforms. Each byte describes one bit-clock period. Its lowest bit is the level of the word (left/right) clock, and the seven bits above it are the levels of seven serial data lines. The block does not assemble samples. It divides the master clock down to a bit clock and takes one byte from a show-ahead input FIFO in every bit-clock period. It then places all eight bits on registered pins on the falling edge of that bit clock.

Sixty-four consecutive bytes form one left/right cycle, which carries fourteen channels across the seven data lines. The block knows nothing of this framing: it only paces and reclocks bits. To change the sample rate, change the master clock or the divide setting; the byte format does not change. When the FIFO has nothing to give at a pull point, the block keeps the word clock where it was, forces the data lines low and raises a sticky underrun flag.

Top module: `byte_i2s_player`

## Requirements
- R1: A byte taken from the FIFO appears on the pins on the same master clock edge that consumes it. Bit 0 drives `wclk`, and bits 1 to 7 drive `sdata[0]` to `sdata[6]`.
- R2: `div_sel` values 0, 1, 2 and 3 give a bit clock of 2, 4, 8 and 16 master clock cycles, with equal high and low halves. Exactly one pull occurs per bit-clock period, so consecutive `fifo_rd` pulses are that many cycles apart.
- R3: `wclk` and `sdata` change only on the master clock edge where `bclk` falls, and they change together from one register stage.
- R4: After `enable` rises, the first byte is consumed on the first falling edge of `bclk`. That is the master clock edge numbered ratio after enable is first sampled high, so `fifo_rd` is first seen after ratio-1 edges.
- R5: `fifo_rd` is a one-cycle pulse, raised only while `bclk` is high at a pull point and only when `fifo_empty` is low.
- R6: At a pull point with the FIFO empty, `wclk` keeps its previous level, all data lines go low, `underrun` becomes 1 and no read is issued.
- R7: `underrun` stays at 1 until `clr_underrun` is high on a clock edge, after which it reads 0.
- R8: While `enable` is low, `bclk` is low from the next edge on, no FIFO read occurs, and `wclk` and `sdata` hold their values.
- R9: During and after reset (`rst_n` low), `bclk`, `wclk`, `sdata`, `underrun` and `fifo_rd` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Run the bit clock and pull bytes |
| div_sel | input | 2 | Bit clock divide select: 2, 4, 8 or 16 |
| fifo_empty | input | 1 | Show-ahead FIFO has no byte |
| fifo_data | input | 8 | Head byte of the FIFO |
| fifo_rd | output | 1 | Consume the head byte on this edge |
| clr_underrun | input | 1 | Clear the sticky underrun flag |
| bclk | output | 1 | Serial bit clock |
| wclk | output | 1 | Word (left/right) clock |
| sdata | output | 7 | Serial data lines 1 to 7 |
| underrun | output | 1 | Sticky flag: a pull found the FIFO empty |

## Verification
The hardest situation to reach is a pull point that lands on an empty FIFO. The word clock must then stay where the last real byte left it, and the flag must survive a later disable until it is cleared explicitly. For every divide setting, the stimulus fills a bench FIFO model with a computed pattern and streams it out completely. It then lets the FIFO drain, so the next pull meets emptiness and the held word clock level is known from the final byte. Disabling with a refilled FIFO then shows that no reads leak out and that the flag stays set until it is cleared.

// File: rtl/byte_i2s_pkg.sv
// Shared constants for the byte-packed I2S player.
// Assumes the byte layout: word clock in the lowest bit, data lines above it.
package byte_i2s_pkg;
    localparam int WORD_BIT       = 0;
    localparam int FIRST_DATA_BIT = 1;
    localparam int SEL_WIDTH      = 2;
endpackage

// File: rtl/byte_i2s_bclk_gen.sv
// Bit clock divider.
// Produces bclk from the master clock with a half period of 2**div_sel
// master cycles. Raises a one-cycle pull strobe in the last master cycle
// of the bclk high phase, so the consuming edge is the bclk falling edge.
// Assumes div_sel is static while enabled (a change takes effect at the
// next half-period boundary).
module byte_i2s_bclk_gen #(
    parameter int SEL_W = byte_i2s_pkg::SEL_WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [SEL_W-1:0] div_sel,
    output logic             bclk,
    output logic             pull
);
    localparam int HALF_W = 1 << SEL_W;

    logic [HALF_W-1:0] cnt;
    logic [HALF_W-1:0] half_m1;
    logic              at_end;

    // Terminal count of one bclk half period.
    always_comb begin
        half_m1 = HALF_W'((HALF_W'(1) << div_sel) - HALF_W'(1));
        at_end  = (cnt >= half_m1);
    end

    // Half-period counter and bclk toggle; parked low when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            cnt  <= '0;
            bclk <= 1'b0;
        end else if (at_end) begin
            cnt  <= '0;
            bclk <= ~bclk;
        end else begin
            cnt  <= cnt + HALF_W'(1);
        end
    end

    // Pull on the edge that ends the high phase.
    assign pull = enable & bclk & at_end;
endmodule

// File: rtl/byte_i2s_pin_stage.sv
// Output register stage.
// On each pull strobe, loads the FIFO head byte into the pin register, or,
// if the FIFO is empty, keeps the word clock level, zeroes the data lines
// and sets the sticky underrun flag. Assumes a show-ahead FIFO whose head
// byte is valid whenever fifo_empty is low.
module byte_i2s_pin_stage #(
    parameter int LINES = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pull,
    input  logic             fifo_empty,
    input  logic [LINES:0]   fifo_data,
    input  logic             clr_underrun,
    output logic             fifo_rd,
    output logic [LINES:0]   pins,
    output logic             underrun
);
    import byte_i2s_pkg::*;

    // Read only when a pull finds data.
    assign fifo_rd = pull & ~fifo_empty;

    // Word clock flop: load on read, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)       pins[WORD_BIT] <= 1'b0;
        else if (fifo_rd) pins[WORD_BIT] <= fifo_data[WORD_BIT];
    end

    // One flop per data line: load on read, clear on an empty pull.
    for (genvar g = FIRST_DATA_BIT; g <= LINES; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (!rst_n)    pins[g] <= 1'b0;
            else if (pull) pins[g] <= fifo_empty ? 1'b0 : fifo_data[g];
        end
    end

    // Sticky underrun: a new empty pull wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                   underrun <= 1'b0;
        else if (pull && fifo_empty)  underrun <= 1'b1;
        else if (clr_underrun)        underrun <= 1'b0;
    end
endmodule

// File: rtl/byte_i2s_player.sv
// Byte-packed parallel I2S player, top level.
// Divides the master clock into a bit clock, takes one FIFO byte per bit
// period and drives word clock plus data lines from a single register.
// Assumes the host already encoded the I2S timing in the byte stream.
module byte_i2s_player #(
    parameter int DATA_LINES = 7,
    parameter int SEL_W      = byte_i2s_pkg::SEL_WIDTH
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  enable,
    input  logic [SEL_W-1:0]      div_sel,
    input  logic                  fifo_empty,
    input  logic [DATA_LINES:0]   fifo_data,
    output logic                  fifo_rd,
    input  logic                  clr_underrun,
    output logic                  bclk,
    output logic                  wclk,
    output logic [DATA_LINES-1:0] sdata,
    output logic                  underrun
);
    import byte_i2s_pkg::*;

    logic                pull;
    logic [DATA_LINES:0] pins;

    byte_i2s_bclk_gen #(.SEL_W(SEL_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable),
        .div_sel (div_sel),
        .bclk    (bclk),
        .pull    (pull)
    );

    byte_i2s_pin_stage #(.LINES(DATA_LINES)) u_pins (
        .clk          (clk),
        .rst_n        (rst_n),
        .pull         (pull),
        .fifo_empty   (fifo_empty),
        .fifo_data    (fifo_data),
        .clr_underrun (clr_underrun),
        .fifo_rd      (fifo_rd),
        .pins         (pins),
        .underrun     (underrun)
    );

    // Split the pin register into word clock and data lines.
    assign wclk  = pins[WORD_BIT];
    assign sdata = pins[DATA_LINES:FIRST_DATA_BIT];
endmodule

// File: rtl/byte_i2s_player_chk.sv
// Protocol checker for byte_i2s_player, attached with bind.
// Assumes synchronous active-low reset on rst_n.
module byte_i2s_player_chk #(
    parameter int DATA_LINES = 7
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  enable,
    input logic                  fifo_empty,
    input logic [DATA_LINES:0]   fifo_data,
    input logic                  fifo_rd,
    input logic                  clr_underrun,
    input logic                  bclk,
    input logic                  wclk,
    input logic [DATA_LINES-1:0] sdata,
    input logic                  underrun
);
    // R1: a consumed byte lands on the pins at the consuming edge.
    a_r1_byte_to_pins: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd |=> ({sdata, wclk} == $past(fifo_data)));

    // R3: pins move only where bclk falls.
    a_r3_pins_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(bclk) |-> $stable({sdata, wclk}));

    // R5: never read an empty FIFO.
    a_r5_no_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd |-> !fifo_empty);

    // R5: read only in the high phase of bclk.
    a_r5_read_in_high: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd |-> bclk);

    // R6: an empty pull holds word clock, zeroes data, flags underrun.
    a_r6_empty_pull: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(bclk) && $past(enable) && $past(fifo_empty)) |->
            (sdata == '0 && underrun && wclk == $past(wclk)));

    // R7: underrun is sticky without a clear.
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (underrun && !clr_underrun) |=> underrun);

    // R8: disabled means bclk low next cycle and no reads.
    a_r8_idle_bclk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !bclk);
    a_r8_idle_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> !fifo_rd);
endmodule

bind byte_i2s_player byte_i2s_player_chk #(.DATA_LINES(DATA_LINES)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (enable),
    .fifo_empty   (fifo_empty),
    .fifo_data    (fifo_data),
    .fifo_rd      (fifo_rd),
    .clr_underrun (clr_underrun),
    .bclk         (bclk),
    .wclk         (wclk),
    .sdata        (sdata),
    .underrun     (underrun)
);

// File: tb/byte_i2s_player_test.sv
// Sweeps every divide setting, streams a computed byte pattern through a
// show-ahead FIFO model, then drains it to force an underrun.
module byte_i2s_player_test;
    logic       clk = 1'b0;
    logic       rst_n, enable, clr_underrun, rewind;
    logic [1:0] div_sel;
    logic       fifo_empty, fifo_rd, bclk, wclk, underrun;
    logic [7:0] fifo_data;
    logic [6:0] sdata;
    logic [7:0] mem [256];
    int         rd_idx = 0;
    int         avail  = 0;
    int         tests  = 0;
    int         fails  = 0;

    always #10 clk = ~clk;

    byte_i2s_player uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .div_sel(div_sel),
        .fifo_empty(fifo_empty), .fifo_data(fifo_data), .fifo_rd(fifo_rd),
        .clr_underrun(clr_underrun), .bclk(bclk), .wclk(wclk),
        .sdata(sdata), .underrun(underrun)
    );

    // Show-ahead FIFO model.
    assign fifo_empty = (rd_idx >= avail);
    assign fifo_data  = fifo_empty ? 8'h00 : mem[rd_idx & 255];
    always @(posedge clk) begin
        if (rewind)       rd_idx <= 0;
        else if (fifo_rd) rd_idx <= rd_idx + 1;
    end

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Count edges until fifo_rd is seen (bounded).
    task automatic wait_rd(output int n);
        n = 0;
        while (!fifo_rd && n < 100) begin
            step();
            n++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R2 watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int n, ratio, cnt_n, bad;
        logic [7:0] last;
        rst_n = 1'b0; enable = 1'b0; div_sel = 2'd0;
        clr_underrun = 1'b0; rewind = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R9 bclk", int'(bclk), 0);
        chk("R9 wclk", int'(wclk), 0);
        chk("R9 sdata", int'(sdata), 0);
        chk("R9 underrun", int'(underrun), 0);
        chk("R9 fifo_rd", int'(fifo_rd), 0);
        rst_n = 1'b1;

        for (int s = 0; s < 4; s++) begin
            ratio = 2 << s;
            cnt_n = (s == 0) ? 256 : 40;
            div_sel = 2'(s);
            for (int i = 0; i < 256; i++) mem[i] = 8'((i * 37 + s * 11) & 255);
            avail  = cnt_n;
            rewind = 1'b1;
            step();
            rewind = 1'b0;
            enable = 1'b1;
            wait_rd(n);
            chk("R4 first pull delay", n, ratio - 1);
            for (int k = 0; k < cnt_n; k++) begin
                if (k > 0) begin
                    wait_rd(n);
                    chk("R2 pull spacing", n, ratio - 1);
                end
                chk("R5 read in bclk high", int'(bclk), 1);
                step();
                chk("R1 pins match byte", int'({sdata, wclk}), int'(mem[k]));
                chk("R3 bclk fell with pins", int'(bclk), 0);
                chk("R5 single-cycle read", int'(fifo_rd), 0);
            end
            chk("R6 no underrun while fed", int'(underrun), 0);
            last = mem[cnt_n - 1];
            bad  = 0;
            for (int c = 0; c < ratio; c++) begin
                step();
                if (fifo_rd) bad++;
            end
            chk("R5 no read when empty", bad, 0);
            chk("R6 underrun set", int'(underrun), 1);
            chk("R6 data lines low", int'(sdata), 0);
            chk("R6 wclk held", int'(wclk), int'(last[0]));

            enable = 1'b0;
            rewind = 1'b1;
            step();
            rewind = 1'b0;
            chk("R8 bclk low when off", int'(bclk), 0);
            bad = 0;
            for (int c = 0; c < 20; c++) begin
                step();
                if (fifo_rd || bclk) bad++;
            end
            chk("R8 no read or clock when off", bad, 0);
            chk("R8 wclk holds when off", int'(wclk), int'(last[0]));
            chk("R7 underrun sticky", int'(underrun), 1);
            clr_underrun = 1'b1;
            step();
            clr_underrun = 1'b0;
            chk("R7 underrun cleared", int'(underrun), 0);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule